// File: doc/BRIEF.md
# HDLC Receive Frame Formatter

This block takes a serial HDLC line, one bit each time its bit strobe is high, and turns every frame into bytes for a byte-wide receive FIFO. It finds opening and closing flags and removes the zeros that the sender inserted after runs of five ones. It spots aborts and checks the 16-bit frame check sequence. It writes each received byte to the FIFO with a one-clock strobe and then closes the frame with a status byte, which alone carries the end-of-frame marker.

Two configuration inputs shape what reaches the FIFO. When address keeping is off, the leading address field is dropped. That field is one or two bytes, as chosen by an address-size input. When CRC keeping is on, the two check bytes follow the data. When it is off, they are removed. The check sequence is verified in every case. The short-frame limit counts only the stored payload, so keeping the check bytes raises the stored minimum by two. Configuration is expected to stay stable while a frame is being received.

Top module: `hdlc_rx_formatter`

## Requirements
- R1: A flag is the pattern 01111110. A frame is the data between two flags. Flags that follow each other with no data between them cause no FIFO write.
- R2: Inside a frame, a 0 that comes right after five consecutive 1s is removed before byte assembly. Bytes are assembled LSB first.
- R3: When `addr_push` is 1, every received byte is kept. When it is 0, the first byte (`addr_two`=0) or the first two bytes (`addr_two`=1) of the frame are not written.
- R4: When `crc_push` is 1, the last two complete bytes of the frame (the check sequence) are written after the data and before the status byte. When it is 0, they are not written.
- R5: Each frame produces exactly one status byte, written last. `wr_eof` is 1 only with the status byte. `wr_en` is high for one clock per byte. Status bits 7:5 are 0.
- R6: Status bit 0 is 1 when the CRC-16 register over all frame bits, including the check sequence, equals 0xF0B8. The register starts at 0xFFFF, uses reflected polynomial 0x8408 and takes bits in arrival order. This holds whatever `crc_push` is.
- R7: Seven consecutive 1s after at least one data bit abort the frame. Held bytes are discarded, and a status byte of 0x02 is written (bit 1 = abort, bits 0, 2 and 3 = 0, plus bit 4 if an overflow occurred). The receiver then waits for a flag.
- R8: Status bit 2 (too short) is 1 when the number of complete received bytes is less than 2 + MIN_BYTES + the number of dropped address bytes. MIN_BYTES defaults to 1.
- R9: Status bit 3 (non-octet) is 1 when the frame bit count is not a multiple of 8. Trailing partial bits are not written.
- R10: A data or check byte due while `fifo_full` is 1 is not strobed, and status bit 4 of that frame is set. The status byte is always written.
- R11: While in reset and before the first flag after reset, no write occurs, whatever the line carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_en | input | 1 | Line bit strobe; `bit_in` is taken when high |
| bit_in | input | 1 | Serial line data |
| addr_push | input | 1 | 1 = keep the address field |
| addr_two | input | 1 | 1 = two-byte address field, 0 = one byte |
| crc_push | input | 1 | 1 = write the two check bytes |
| fifo_full | input | 1 | FIFO cannot accept a data byte |
| wr_en | output | 1 | One-clock byte write strobe |
| wr_data | output | 8 | Byte written to the FIFO |
| wr_eof | output | 1 | Marks the status byte that closes a frame |

## Verification
The hardest cases to reach from the pins are those where a bit run touches a flag. One is a stuffed zero that sits just before the closing flag. Another is check bytes whose own bit runs force stuffing, so that the six-bit lookahead must drop the flag's leading bits exactly. The stimulus gets there with payloads of 0xFF and 0x7E bytes, and with random payloads whose check bytes often carry long runs of ones. These are mixed with random gaps between bit strobes. Aborts, non-octet tails, forced CRC errors and a full FIFO are driven as directed frames, with the address and CRC options varied across them.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;

  localparam logic [15:0] CRC_INIT = 16'hFFFF;
  localparam logic [15:0] CRC_GOOD = 16'hF0B8;
  localparam logic [15:0] CRC_POLY = 16'h8408;

  // one bit of the reflected CRC-16, bit taken in line order
  function automatic logic [15:0] crc16_bit(input logic [15:0] c, input logic b);
    logic fb;
    fb = c[0] ^ b;
    return fb ? ((c >> 1) ^ CRC_POLY) : (c >> 1);
  endfunction

  // status byte: {000, overflow, non-octet, short, abort, crc ok}
  function automatic logic [7:0] pack_status(input logic ok, input logic ab,
                                             input logic sh, input logic no,
                                             input logic ov);
    return {3'b000, ov, no, sh, ab, ok};
  endfunction

endpackage

// File: rtl/hdlc_rx_deframer.sv
module hdlc_rx_deframer #(
  parameter int FLAG_ONES = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic bit_in,
  output logic dvalid,
  output logic dbit,
  output logic flag_evt,
  output logic abort_evt
);

  localparam int STUFF_RUN = FLAG_ONES - 1;
  localparam int PIPE_LEN  = FLAG_ONES;
  localparam int ONES_MAX  = FLAG_ONES + 1;
  localparam int ONES_W    = $clog2(ONES_MAX + 1);
  localparam int PCNT_W    = $clog2(PIPE_LEN + 1);

  logic [ONES_W-1:0]   ones_q;
  logic [PIPE_LEN-1:0] pipe_q;
  logic [PCNT_W-1:0]   pcnt_q;
  logic                hunt_q;

  logic is_flag, is_abort, is_stuff, push, pipe_full;

  always_comb begin
    is_flag   = bit_en && !bit_in && (ones_q == ONES_W'(FLAG_ONES));
    is_abort  = bit_en &&  bit_in && (ones_q == ONES_W'(FLAG_ONES));
    is_stuff  = bit_en && !bit_in && (ones_q == ONES_W'(STUFF_RUN));
    pipe_full = (pcnt_q == PCNT_W'(PIPE_LEN));
    push      = bit_en && !is_flag && !is_stuff &&
                (bit_in ? (ones_q < ONES_W'(STUFF_RUN)) : 1'b1);
  end

  assign dvalid    = push && pipe_full && !hunt_q;
  assign dbit      = pipe_q[0];
  assign flag_evt  = is_flag;
  assign abort_evt = is_abort && !hunt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ones_q <= '0;
      pipe_q <= '0;
      pcnt_q <= '0;
      hunt_q <= 1'b1;
    end else if (bit_en) begin
      if (bit_in)
        ones_q <= (ones_q == ONES_W'(ONES_MAX)) ? ones_q : ones_q + 1'b1;
      else
        ones_q <= '0;
      if (is_flag || is_abort) begin
        pipe_q <= '0;
        pcnt_q <= '0;
        hunt_q <= is_abort;
      end else if (push) begin
        pipe_q <= {bit_in, pipe_q[PIPE_LEN-1:1]};
        pcnt_q <= pipe_full ? pcnt_q : pcnt_q + 1'b1;
      end
    end
  end

  // R1: the flag's own leading bits never leak out as data
  a_r1_flag_clears_pipe: assert property (@(posedge clk) disable iff (!rst_n)
    flag_evt |=> !dvalid);

  // R11: nothing is delivered while hunting for the first flag
  a_r11_hunt_silent: assert property (@(posedge clk) disable iff (!rst_n)
    hunt_q |-> !dvalid && !abort_evt);

endmodule

// File: rtl/hdlc_rx_assembler.sv
module hdlc_rx_assembler
  import hdlc_rx_pkg::*;
#(
  parameter int MIN_BYTES = 1,
  parameter int CNT_W     = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dvalid,
  input  logic       dbit,
  input  logic       flag_evt,
  input  logic       abort_evt,
  input  logic       addr_push,
  input  logic       addr_two,
  input  logic       crc_push,
  input  logic       fifo_full,
  output logic       wr_en,
  output logic [7:0] wr_data,
  output logic       wr_eof
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             active_q;
  logic [7:0]       sh_q;
  logic [2:0]       bitcnt_q;
  logic [CNT_W-1:0] nbytes_q;
  logic [1:0]       nheld_q;
  logic [7:0]       hold0_q, hold1_q;
  logic [15:0]      crc_q;
  logic             ovf_q;

  logic [1:0]       sq_pend_q;
  logic             st_pend_q;
  logic [7:0]       cr0_q, cr1_q, st_q;
  logic             wr_en_q, wr_eof_q;
  logic [7:0]       wr_data_q;

  logic       byte_done, emit_data, frame_end, frame_abort, seq_busy, too_short;
  logic [7:0] new_byte, status_now;
  logic [1:0] drop_cnt;

  always_comb begin
    drop_cnt    = addr_push ? 2'd0 : (addr_two ? 2'd2 : 2'd1);
    byte_done   = dvalid && (bitcnt_q == 3'd7);
    new_byte    = {dbit, sh_q[7:1]};
    emit_data   = byte_done && (nheld_q == 2'd2) &&
                  !((nbytes_q - CNT_W'(2)) < CNT_W'(drop_cnt));
    frame_end   = flag_evt && active_q;
    frame_abort = abort_evt && active_q;
    seq_busy    = (sq_pend_q != 2'd0) || st_pend_q;
    too_short   = int'(nbytes_q) < (2 + MIN_BYTES + int'(drop_cnt));
    status_now  = frame_abort ? pack_status(1'b0, 1'b1, 1'b0, 1'b0, ovf_q)
                              : pack_status(crc_q == CRC_GOOD, 1'b0, too_short,
                                            bitcnt_q != 3'd0, ovf_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q  <= 1'b0;
      sh_q      <= '0;
      bitcnt_q  <= '0;
      nbytes_q  <= '0;
      nheld_q   <= '0;
      hold0_q   <= '0;
      hold1_q   <= '0;
      crc_q     <= CRC_INIT;
      ovf_q     <= 1'b0;
      sq_pend_q <= '0;
      st_pend_q <= 1'b0;
      cr0_q     <= '0;
      cr1_q     <= '0;
      st_q      <= '0;
      wr_en_q   <= 1'b0;
      wr_eof_q  <= 1'b0;
      wr_data_q <= '0;
    end else begin
      wr_en_q  <= 1'b0;
      wr_eof_q <= 1'b0;

      // output port: data bytes, then held check bytes, then status
      if (emit_data) begin
        if (fifo_full) ovf_q <= 1'b1;
        else begin
          wr_en_q   <= 1'b1;
          wr_data_q <= hold0_q;
        end
      end else if (sq_pend_q != 2'd0) begin
        if (fifo_full) st_q[4] <= 1'b1;
        else begin
          wr_en_q   <= 1'b1;
          wr_data_q <= cr0_q;
        end
        cr0_q     <= cr1_q;
        sq_pend_q <= sq_pend_q - 2'd1;
      end else if (st_pend_q) begin
        wr_en_q   <= 1'b1;
        wr_eof_q  <= 1'b1;
        wr_data_q <= st_q;
        st_pend_q <= 1'b0;
      end

      // closing: latch status and the held pair for the sequencer
      if (frame_end || frame_abort) begin
        st_q      <= status_now;
        st_pend_q <= 1'b1;
        sq_pend_q <= (frame_end && crc_push) ? nheld_q : 2'd0;
        cr0_q     <= hold0_q;
        cr1_q     <= hold1_q;
      end

      // frame state
      if (flag_evt || abort_evt) begin
        active_q <= 1'b0;
        bitcnt_q <= '0;
        nbytes_q <= '0;
        nheld_q  <= '0;
        crc_q    <= CRC_INIT;
        ovf_q    <= 1'b0;
      end else if (dvalid) begin
        active_q <= 1'b1;
        sh_q     <= new_byte;
        bitcnt_q <= bitcnt_q + 3'd1;
        crc_q    <= crc16_bit(crc_q, dbit);
        if (byte_done) begin
          if (nbytes_q != CNT_MAX) nbytes_q <= nbytes_q + 1'b1;
          case (nheld_q)
            2'd0: begin hold0_q <= new_byte; nheld_q <= 2'd1; end
            2'd1: begin hold1_q <= new_byte; nheld_q <= 2'd2; end
            default: begin hold0_q <= hold1_q; hold1_q <= new_byte; end
          endcase
        end
      end
    end
  end

  assign wr_en   = wr_en_q;
  assign wr_data = wr_data_q;
  assign wr_eof  = wr_eof_q;

  // R5: end marker only rides on a strobed byte
  a_r5_eof_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    wr_eof |-> wr_en);

  // R5: status byte upper bits are zero
  a_r5_status_top_zero: assert property (@(posedge clk) disable iff (!rst_n)
    wr_eof |-> (wr_data[7:5] == 3'b000));

  // R5: one status byte per frame, never two in a row
  a_r5_single_eof: assert property (@(posedge clk) disable iff (!rst_n)
    wr_eof |=> !wr_eof);

  // R7: an aborted frame reports no CRC, length or alignment result
  a_r7_abort_status: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_eof && wr_data[1]) |-> (wr_data[3:0] == 4'b0010));

  // R10: no data strobe follows a full indication
  a_r10_no_write_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_eof) |-> !$past(fifo_full));

  // R4: the close sequence finishes before the next frame's bits arrive
  a_r4_close_before_data: assert property (@(posedge clk) disable iff (!rst_n)
    seq_busy |-> !dvalid);

endmodule

// File: rtl/hdlc_rx_formatter.sv
module hdlc_rx_formatter #(
  parameter int FLAG_ONES = 6,
  parameter int MIN_BYTES = 1,
  parameter int CNT_W     = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_en,
  input  logic       bit_in,
  input  logic       addr_push,
  input  logic       addr_two,
  input  logic       crc_push,
  input  logic       fifo_full,
  output logic       wr_en,
  output logic [7:0] wr_data,
  output logic       wr_eof
);

  logic dvalid, dbit, flag_evt, abort_evt;

  hdlc_rx_deframer #(
    .FLAG_ONES(FLAG_ONES)
  ) u_deframer (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_en    (bit_en),
    .bit_in    (bit_in),
    .dvalid    (dvalid),
    .dbit      (dbit),
    .flag_evt  (flag_evt),
    .abort_evt (abort_evt)
  );

  hdlc_rx_assembler #(
    .MIN_BYTES(MIN_BYTES),
    .CNT_W    (CNT_W)
  ) u_assembler (
    .clk       (clk),
    .rst_n     (rst_n),
    .dvalid    (dvalid),
    .dbit      (dbit),
    .flag_evt  (flag_evt),
    .abort_evt (abort_evt),
    .addr_push (addr_push),
    .addr_two  (addr_two),
    .crc_push  (crc_push),
    .fifo_full (fifo_full),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .wr_eof    (wr_eof)
  );

endmodule

// File: tb/sim_hdlc_rx_formatter.sv
`timescale 1ns/1ps
module sim_hdlc_rx_formatter;

  logic clk = 1'b0;
  logic rst_n, bit_en, bit_in, addr_push, addr_two, crc_push, fifo_full;
  logic wr_en, wr_eof;
  logic [7:0] wr_data;

  always #10 clk = ~clk;

  hdlc_rx_formatter u0 (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in),
    .addr_push(addr_push), .addr_two(addr_two), .crc_push(crc_push),
    .fifo_full(fifo_full), .wr_en(wr_en), .wr_data(wr_data), .wr_eof(wr_eof)
  );

  int tests = 0, fails = 0, tx_ones = 0;
  bit done = 0, gap_en = 0;
  logic [7:0] got[$];
  bit gote[$];

  always @(negedge clk)
    if (rst_n === 1'b1 && wr_en === 1'b1) begin
      got.push_back(wr_data);
      gote.push_back(wr_eof);
    end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_crc(input logic bits[$]);
    logic [15:0] c = 16'hFFFF;
    foreach (bits[i]) begin
      logic [15:0] x = c ^ {15'd0, bits[i]};
      c = (c >> 1) ^ ({16{x[0]}} & 16'h8408);
    end
    return c;
  endfunction

  task automatic tx_raw(input logic b);
    bit_in = b;
    bit_en = 1'b1;
    @(negedge clk);
    bit_en = 1'b0;
    if (gap_en) repeat ($urandom_range(0, 2)) @(negedge clk);
  endtask

  task automatic tx_flag();
    tx_raw(0); repeat (6) tx_raw(1); tx_raw(0);
    tx_ones = 0;
  endtask

  task automatic tx_data(input logic b);
    tx_raw(b);
    if (b) begin
      tx_ones++;
      if (tx_ones == 5) begin tx_raw(0); tx_ones = 0; end
    end else tx_ones = 0;
  endtask

  task automatic run_frame(input logic [7:0] d[$], input int extra, input bit abort,
                           input bit bad, input string tag);
    logic bits[$];
    logic [7:0] rx[$];
    logic [7:0] exp[$];
    logic [15:0] fcs;
    int nb, drop, kept, mism;
    bit ovf;
    logic [7:0] st;
    got.delete(); gote.delete();
    foreach (d[i]) begin
      for (int k = 0; k < 8; k++) bits.push_back(d[i][k]);
      rx.push_back(d[i]);
    end
    fcs = ~ref_crc(bits) ^ {15'd0, bad};
    for (int k = 0; k < 16; k++) bits.push_back(fcs[k]);
    rx.push_back(fcs[7:0]);
    rx.push_back(fcs[15:8]);
    for (int k = 0; k < extra; k++) bits.push_back(1'($urandom_range(0, 1)));
    tx_flag();
    foreach (bits[i]) tx_data(bits[i]);
    if (abort) repeat (10) tx_raw(1);
    else tx_flag();
    repeat (10) @(negedge clk);
    if (abort) begin
      check(got.size() > 0 && gote[got.size()-1] && got[got.size()-1] == 8'h02,
            {tag, " R7 abort status"}, got.size() > 0 ? got[got.size()-1] : -1, 8'h02);
      return;
    end
    nb = rx.size();
    drop = addr_push ? 0 : (addr_two ? 2 : 1);
    kept = 0;
    for (int i = 0; i < nb - 2; i++)
      if (i >= drop) begin exp.push_back(rx[i]); kept++; end
    if (crc_push) for (int i = nb - 2; i < nb; i++) begin exp.push_back(rx[i]); kept++; end
    ovf = fifo_full && (kept > 0);
    if (fifo_full) exp.delete();
    st = {3'b000, ovf, extra % 8 != 0, nb < 2 + 1 + drop, 1'b0,
          ref_crc(bits) == 16'hF0B8};
    exp.push_back(st);
    mism = 0;
    if (got.size() == exp.size())
      foreach (exp[i]) if (got[i] != exp[i] || gote[i] != (i == exp.size() - 1)) mism++;
    check(got.size() == exp.size() && mism == 0, {tag, " R3 R4 R5 byte list"},
          got.size(), exp.size());
    check(got.size() > 0 && got[got.size()-1] == st && gote[got.size()-1],
          {tag, " R6 R8 R9 R10 status"},
          got.size() > 0 ? got[got.size()-1] : -1, st);
  endtask

  initial begin
    logic [7:0] q[$];
    void'($urandom(32'h5EED_1234));
    rst_n = 0; bit_en = 0; bit_in = 1; addr_push = 1; addr_two = 0;
    crc_push = 0; fifo_full = 0;
    repeat (4) @(negedge clk);
    check(wr_en == 0 && wr_eof == 0, "R11 reset outputs", {wr_en, wr_eof}, 0);
    rst_n = 1;
    @(negedge clk);
    repeat (14) tx_raw(1);
    tx_raw(0); tx_raw(1); tx_raw(0);
    repeat (10) tx_raw(1);
    repeat (5) @(negedge clk);
    check(got.size() == 0, "R11 no write before first flag", got.size(), 0);

    got.delete();
    repeat (4) tx_flag();
    repeat (5) @(negedge clk);
    check(got.size() == 0, "R1 back-to-back flags", got.size(), 0);

    q = '{8'hA1, 8'h03, 8'h55};
    addr_push = 1; addr_two = 0; crc_push = 0; run_frame(q, 0, 0, 0, "R3 keep addr");
    addr_push = 0; addr_two = 0; run_frame(q, 0, 0, 0, "R3 drop one");
    addr_push = 0; addr_two = 1; run_frame(q, 0, 0, 0, "R3 drop two");
    addr_push = 1; crc_push = 1; run_frame(q, 0, 0, 0, "R4 keep crc");
    q = '{8'hFF, 8'hFF, 8'h7E, 8'h3F, 8'hF8};
    run_frame(q, 0, 0, 0, "R2 stuffing");
    crc_push = 0; run_frame(q, 0, 0, 0, "R2 stuffing nocrc");
    run_frame(q, 0, 0, 1, "R6 bad crc");
    crc_push = 1; run_frame(q, 0, 0, 1, "R6 bad crc kept");
    q.delete();
    run_frame(q, 0, 0, 0, "R8 empty kept crc");
    crc_push = 0; addr_push = 0; q = '{8'h11};
    run_frame(q, 0, 0, 0, "R8 short after drop");
    addr_push = 1; q = '{8'h12, 8'h34};
    run_frame(q, 3, 0, 0, "R9 non-octet");
    fifo_full = 1; crc_push = 1; q = '{8'h01, 8'h02, 8'h03};
    run_frame(q, 0, 0, 0, "R10 full fifo");
    fifo_full = 0; crc_push = 0;
    run_frame(q, 0, 1, 0, "R7 abort");
    run_frame(q, 0, 0, 0, "R1 after abort");

    gap_en = 1;
    for (int n = 0; n < 40; n++) begin
      q.delete();
      repeat ($urandom_range(0, 7)) q.push_back(8'($urandom_range(0, 255)));
      addr_push = 1'($urandom_range(0, 1));
      addr_two  = 1'($urandom_range(0, 1));
      crc_push  = 1'($urandom_range(0, 1));
      fifo_full = ($urandom_range(0, 9) == 0);
      run_frame(q, ($urandom_range(0, 5) == 0) ? int'($urandom_range(1, 7)) : 0,
                ($urandom_range(0, 9) == 0) && (q.size() > 1), 0, "R5 random");
      fifo_full = 0;
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #3_000_000;
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule